// File: doc/BRIEF.md
# Serial Transmitter with Holding Stage

This block turns parallel characters into an asynchronous serial stream. A host pushes a character of 5 to 8 bits through a valid/ready write port into a single holding stage. When transmission is allowed, the character moves into a frame register at a baud tick. It is sent as a low start bit, the data bits least significant first, an optional parity bit and a high stop bit. Each bit lasts a fixed number of ticks of an oversampling enable, 16 by default.

The write port follows stream rules. `in_ready` is high exactly when the holding stage is free, so it also serves as the "holding register empty" status. A beat is taken on a clock edge where `in_valid` and `in_ready` are both high. While `in_ready` is low, the source must hold its data or retry, because a beat offered then is dropped. The stage empties as soon as its character starts its frame, so the next character can be written while the current one is still on the line.

A transmit enable gates the move from the holding stage into the frame register. A loopback control steers the framed stream onto a separate line meant for the local receiver and keeps the external line idle. Character size and parity settings are sampled at the start of each frame.

Top module: `utx_top`

## Requirements
- R1: After reset, `txd` and `loop_rxd` are high and `in_ready` is 1.
- R2: A frame is one 0 start bit, then the data bits least significant first, then one 1 stop bit. Each bit lasts OVERSAMPLE ticks of `tick16`, and the line returns high afterwards.
- R3: `cfg_size` selects the data bit count: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Only the low bits of `in_data` are sent, and the bits above them are dropped.
- R4: With `cfg_par_en`=1, a parity bit follows the last data bit. With `cfg_par_odd`=0 it makes the number of ones in data plus parity even, and with `cfg_par_odd`=1 it makes that number odd.
- R5: `in_ready` is 1 whenever the holding stage is free. A beat with `in_valid`=1 and `in_ready`=1 is stored, and `in_ready` is 0 in the following cycle.
- R6: A beat offered while `in_ready` is 0 is ignored. The character already held is the one that is sent later.
- R7: While `tx_en` is 0, a held character stays in the holding stage, `in_ready` stays 0 and the lines stay high.
- R8: The holding stage is freed when its character starts a frame. A second character written during that frame is sent in the next frame.
- R9: With `loopback`=1, the frame appears on `loop_rxd` and `txd` stays high. With `loopback`=0, `loop_rxd` stays high.
- R10: A frame that has started runs to its stop bit even if `tx_en` falls during it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | Oversampling enable, one pulse per tick |
| in_valid | input | 1 | Write beat valid |
| in_ready | output | 1 | Holding stage free (empty flag) |
| in_data | input | DATA_W | Character, right-justified |
| cfg_size | input | 2 | Character size code |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| tx_en | input | 1 | Allows characters to leave the holding stage |
| loopback | input | 1 | Steers frames to `loop_rxd` |
| txd | output | 1 | External serial line |
| loop_rxd | output | 1 | Loopback serial line to the receiver |

## Verification
The assertions check several rules on every cycle. An accepted beat fills the stage, and a held character does not change until it leaves. Nothing leaves the stage while the transmit enable is low, and an idle, disabled transmitter keeps both lines high. The two lines are never low together, and every frame opens with a low line. Only the bench's scenarios can show the bit order, the bit length in ticks, the masking for each character size, the parity value, a full frame surviving a drop of the enable, and two characters travelling back to back through the single holding stage.

// File: rtl/utx_pkg.sv
package utx_pkg;
  typedef enum logic [1:0] {
    SZ_5 = 2'd0,
    SZ_6 = 2'd1,
    SZ_7 = 2'd2,
    SZ_8 = 2'd3
  } char_size_e;

  // number of data bits carried by a frame for a size code
  function automatic logic [3:0] size_bits(char_size_e s);
    return 4'd5 + {2'b00, s};
  endfunction
endpackage

// File: rtl/utx_hold.sv
module utx_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          take,
  output logic          in_ready,
  output logic [DW-1:0] hold_data
);
  logic full_q;
  logic accept;

  assign accept   = in_valid && !full_q;
  assign in_ready = !full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q    <= 1'b0;
      hold_data <= '0;
    end else if (accept) begin
      full_q    <= 1'b1;
      hold_data <= in_data;
    end else if (take) begin
      full_q    <= 1'b0;
    end
  end
endmodule

// File: rtl/utx_bitclk.sv
module utx_bitclk #(
  parameter int OS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run,
  input  logic restart,
  output logic bit_end
);
  localparam int CW = (OS > 1) ? $clog2(OS) : 1;
  logic [CW-1:0] cnt_q;

  assign bit_end = run && tick && (cnt_q == CW'(OS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (restart)
      cnt_q <= '0;
    else if (run && tick)
      cnt_q <= (cnt_q == CW'(OS - 1)) ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/utx_shift.sv
module utx_shift
  import utx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          bit_end,
  input  logic [DW-1:0] data,
  input  char_size_e    size,
  input  logic          par_en,
  input  logic          par_odd,
  output logic          busy,
  output logic          serial
);
  localparam int FW = DW + 3;
  localparam int CW = $clog2(FW + 1);

  logic [FW-1:0] frame_q, frame_d;
  logic [CW-1:0] left_q, nbits;
  logic [DW-1:0] masked;
  logic [3:0]    n;
  logic          par_bit;

  always_comb begin
    n = size_bits(size);
    for (int i = 0; i < DW; i++)
      masked[i] = (i < int'(n)) ? data[i] : 1'b0;
    par_bit = (^masked) ^ par_odd;
    frame_d = '1;
    frame_d[0] = 1'b0;
    for (int i = 0; i < DW; i++)
      if (i < int'(n)) frame_d[i+1] = masked[i];
    if (par_en) frame_d[int'(n)+1] = par_bit;
    nbits = CW'(n) + CW'(par_en) + CW'(2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '1;
      left_q  <= '0;
      busy    <= 1'b0;
    end else if (load) begin
      frame_q <= frame_d;
      left_q  <= nbits;
      busy    <= 1'b1;
    end else if (busy && bit_end) begin
      frame_q <= {1'b1, frame_q[FW-1:1]};
      left_q  <= left_q - 1'b1;
      if (left_q == CW'(1)) busy <= 1'b0;
    end
  end

  assign serial = busy ? frame_q[0] : 1'b1;
endmodule

// File: rtl/utx_top.sv
module utx_top
  import utx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [1:0]        cfg_size,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              tx_en,
  input  logic              loopback,
  output logic              txd,
  output logic              loop_rxd
);
  logic              sh_busy;
  logic              sh_serial;
  logic              load;
  logic              bit_end;
  logic [DATA_W-1:0] hold_q;

  // move held character into the frame register on a tick
  assign load = tick16 && tx_en && !in_ready && !sh_busy;

  utx_hold #(.DW(DATA_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .take      (load),
    .in_ready  (in_ready),
    .hold_data (hold_q)
  );

  utx_bitclk #(.OS(OVERSAMPLE)) u_bitclk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick16),
    .run     (sh_busy),
    .restart (load),
    .bit_end (bit_end)
  );

  utx_shift #(.DW(DATA_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .bit_end (bit_end),
    .data    (hold_q),
    .size    (char_size_e'(cfg_size)),
    .par_en  (cfg_par_en),
    .par_odd (cfg_par_odd),
    .busy    (sh_busy),
    .serial  (sh_serial)
  );

  assign txd      = loopback ? 1'b1 : sh_serial;
  assign loop_rxd = loopback ? sh_serial : 1'b1;
endmodule

// File: rtl/utx_top_chk.sv
module utx_top_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          tx_en,
  input logic          busy,
  input logic          txd,
  input logic          loop_rxd,
  input logic [DW-1:0] hold_data
);
  AST_ACCEPT_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready); // R5

  AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> (in_ready || $stable(hold_data))); // R6

  AST_DISABLED_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && !in_ready) |=> !in_ready); // R7

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && !busy) |=> (txd && loop_rxd)); // R7

  AST_ONE_LINE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (txd || loop_rxd)); // R9

  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !(txd && loop_rxd)); // R2
endmodule

bind utx_top utx_top_chk #(.DW(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .tx_en     (tx_en),
  .busy      (sh_busy),
  .txd       (txd),
  .loop_rxd  (loop_rxd),
  .hold_data (hold_q)
);

// File: tb/utx_top_test.sv
module utx_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic [1:0] cfg_size = 2'd3;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_odd = 1'b0;
  logic       tx_en = 1'b1;
  logic       loopback = 1'b0;
  logic       txd, loop_rxd;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  initial forever begin
    @(negedge clk);
    tick16 = ~tick16;
  end

  utx_top uut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .cfg_size(cfg_size),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .tx_en(tx_en),
    .loopback(loopback), .txd(txd), .loop_rxd(loop_rxd)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [10:0] exp_frame(logic [7:0] d, int n, bit pe, bit po);
    logic [10:0] f;
    bit p;
    f = '1;
    f[0] = 1'b0;
    p = po;
    for (int i = 0; i < n; i++) begin
      f[i+1] = d[i];
      p ^= d[i];
    end
    if (pe) f[n+1] = p;
    return f;
  endfunction

  task automatic wait_ticks(input int k);
    repeat (k) begin
      do @(posedge clk); while (!tick16);
    end
  endtask

  task automatic put(input logic [7:0] d);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic recv(input bit use_loop, input bit drop_en, input int nbits,
                      output logic [10:0] got, output bit other_low);
    int t;
    logic ln, oth;
    t = 0;
    got = '1;
    other_low = 1'b0;
    do begin
      @(negedge clk);
      t++;
      ln = use_loop ? loop_rxd : txd;
    end while (ln !== 1'b0 && t < 3000);
    if (drop_en) tx_en = 1'b0;
    wait_ticks(8);
    for (int i = 0; i < nbits; i++) begin
      if (i > 0) wait_ticks(16);
      @(negedge clk);
      ln  = use_loop ? loop_rxd : txd;
      oth = use_loop ? txd : loop_rxd;
      got[i] = ln;
      if (oth !== 1'b1) other_low = 1'b1;
    end
  endtask

  task automatic t_reset;
    chk(txd === 1'b1, "R1 txd idle", 32'(txd), 1);
    chk(loop_rxd === 1'b1, "R1 loop_rxd idle", 32'(loop_rxd), 1);
    chk(in_ready === 1'b1, "R1 ready after reset", 32'(in_ready), 1);
  endtask

  task automatic t_frame(input string req, input logic [7:0] d, input int n, input bit pe, input bit po);
    logic [10:0] got, exp;
    bit oth;
    cfg_size = 2'(n - 5);
    cfg_par_en = pe;
    cfg_par_odd = po;
    put(d);
    chk(in_ready === 1'b0, "R5 ready low after write", 32'(in_ready), 0);
    exp = exp_frame(d, n, pe, po);
    recv(1'b0, 1'b0, n + 32'(pe) + 2, got, oth);
    chk(got === exp, req, 32'(got), 32'(exp));
    wait_ticks(24);
    @(negedge clk);
    chk(txd === 1'b1, "R2 line high after stop", 32'(txd), 1);
  endtask

  task automatic t_disabled;
    logic [10:0] got;
    bit oth, low_seen;
    cfg_size = 2'd3; cfg_par_en = 1'b0;
    tx_en = 1'b0;
    put(8'h5A);
    low_seen = 1'b0;
    repeat (300) begin
      @(negedge clk);
      if (txd !== 1'b1 || loop_rxd !== 1'b1) low_seen = 1'b1;
    end
    chk(!low_seen, "R7 lines high while disabled", 32'(low_seen), 0);
    chk(in_ready === 1'b0, "R7 character kept while disabled", 32'(in_ready), 0);
    put(8'hC3);
    chk(in_ready === 1'b0, "R6 refused beat leaves stage full", 32'(in_ready), 0);
    tx_en = 1'b1;
    recv(1'b0, 1'b0, 10, got, oth);
    chk(got === exp_frame(8'h5A, 8, 0, 0), "R6 first character sent", 32'(got), 32'(exp_frame(8'h5A, 8, 0, 0)));
    wait_ticks(24);
    chk(in_ready === 1'b1, "R6 no second character held", 32'(in_ready), 1);
  endtask

  task automatic t_drop;
    logic [10:0] got;
    bit oth;
    cfg_size = 2'd3; cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
    put(8'h96);
    recv(1'b0, 1'b1, 11, got, oth);
    chk(got === exp_frame(8'h96, 8, 1, 0), "R10 frame completes after enable drop", 32'(got), 32'(exp_frame(8'h96, 8, 1, 0)));
    tx_en = 1'b1;
    wait_ticks(24);
  endtask

  task automatic t_loop;
    logic [10:0] got;
    bit oth;
    cfg_size = 2'd1; cfg_par_en = 1'b0;
    loopback = 1'b1;
    put(8'hFC);
    recv(1'b1, 1'b0, 8, got, oth);
    chk(got === exp_frame(8'h3C, 6, 0, 0), "R9 frame on loop line", 32'(got), 32'(exp_frame(8'h3C, 6, 0, 0)));
    chk(!oth, "R9 external line held high", 32'(oth), 0);
    wait_ticks(24);
    loopback = 1'b0;
  endtask

  task automatic t_b2b;
    logic [10:0] ga, gb;
    bit oa, ob;
    int wt;
    cfg_size = 2'd3; cfg_par_en = 1'b0;
    put(8'h81);
    fork
      recv(1'b0, 1'b0, 10, ga, oa);
      begin
        wt = 0;
        while (in_ready !== 1'b1 && wt < 100) begin
          @(negedge clk);
          wt++;
        end
        chk(wt < 10, "R8 stage freed at frame start", 32'(wt), 10);
        put(8'h7E);
      end
    join
    recv(1'b0, 1'b0, 10, gb, ob);
    chk(ga === exp_frame(8'h81, 8, 0, 0), "R8 first of pair", 32'(ga), 32'(exp_frame(8'h81, 8, 0, 0)));
    chk(gb === exp_frame(8'h7E, 8, 0, 0), "R8 second of pair", 32'(gb), 32'(exp_frame(8'h7E, 8, 0, 0)));
    wait_ticks(24);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_frame("R2 8-bit frame", 8'hA5, 8, 1'b0, 1'b0);
    t_frame("R3 5-bit frame drops upper bits", 8'hE6, 5, 1'b0, 1'b0);
    t_frame("R4 7-bit even parity", 8'hD3, 7, 1'b1, 1'b0);
    t_frame("R4 8-bit odd parity", 8'h0F, 8, 1'b1, 1'b1);
    t_disabled;
    t_drop;
    t_loop;
    t_b2b;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule